// File: doc/BRIEF.md
# Two-Lane DDR Radar Sample Deserializer

This block takes raw ADC samples from a radar front end. They arrive on two bit-serial lanes, each clocked at double data rate, alongside a frame line. One bit is taken from each lane on every edge of the bit clock. The in-phase word is rebuilt from lane 0 and the quadrature word from lane 1. The words are issued as a stream of complex samples.

Each sample time carries the receive channels one after another. Samples are grouped into chirps, and chirps are grouped into frames. Every output word is tagged with its channel index, sample index and chirp index. The first word of a frame and the last word of a frame are each flagged. A rising edge on the frame line sets the alignment of the whole bit stream.

A frame line that rises again before the current frame is finished is treated as an error. The partial frame is given up, a sticky error flag is raised, and capture starts again at the new frame.

Top module: `radar_ddr_deser`

## Requirements
- R1: From reset, `valid_o` and `err_o` are low. Lane bits that arrive before the first rising edge of `frame_i` after reset produce no output.
- R2: A rising edge on `frame_i` marks the first bit of a frame. That bit is the one sampled on the same rising clock edge where `frame_i` is first seen high after being seen low. The word, channel, sample and chirp counters all restart at that bit.
- R3: Each lane gives two bits per clock cycle: first the bit sampled on the rising edge, then the bit sampled on the falling edge that follows. Each word is `WORD_W` bits, sent MSB first. Lane 0 (`lane_i[0]`) forms `i_o` and lane 1 (`lane_i[1]`) forms `q_o`.
- R4: Within a frame, `chan_o` steps from 0 to `N_CHAN-1` inside each sample. `sample_o` then steps from 0 to `N_SAMPLE-1` inside each chirp, and `chirp_o` steps from 0 to `N_CHIRP-1`.
- R5: `valid_o` is high for exactly one cycle per word. It is due in the cycle after the rising clock edge that follows the word's last (falling-edge) bit, and it is low in every other cycle.
- R6: `frame_start_o` is high only together with the first word of a frame, which has channel, sample and chirp indices all zero.
- R7: `frame_end_o` is high only together with the last word of a frame, which has every index at its maximum. After that word, lane bits produce no output until the next rising edge of `frame_i`.
- R8: If `frame_i` rises before the current frame is complete, the following happens. Words already completed are still issued. The partial word is dropped. `err_o` goes high in the cycle where the new frame's first word count starts, and it stays high until reset. The new frame is then captured normally.
- R9: A rising edge of `frame_i` that arrives after a frame has completed does not set `err_o`, even when it comes directly after that frame's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DDR bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame line; a rising edge marks the first bit of a frame |
| lane_i | input | 2 | Serial lanes: bit 0 carries in-phase, bit 1 carries quadrature |
| valid_o | output | 1 | Output word valid, one cycle per word |
| i_o | output | WORD_W | In-phase word |
| q_o | output | WORD_W | Quadrature word |
| chan_o | output | CH_W | Receive channel index |
| sample_o | output | SMP_W | Sample index within the chirp |
| chirp_o | output | CHP_W | Chirp index within the frame |
| frame_start_o | output | 1 | Set with the first word of a frame |
| frame_end_o | output | 1 | Set with the last word of a frame |
| err_o | output | 1 | Sticky flag for a frame cut short |

## Verification
A word's last bit pair is launched on rising edge n, with its second bit on the falling edge after n. That word's `valid_o`, data, indices and flags must then appear in cycle n+1 and in no other cycle. An early frame edge launched on rising edge n must raise `err_o` from cycle n+1. The bench stamps each expected word with its due cycle at the moment it drives the final pair. It then compares every output on every falling clock edge, so a word that arrives one cycle early or one cycle late is reported as a mismatch. The frame line is held high for several pairs at each frame start, which checks that alignment follows the rising edge rather than the level.

// File: rtl/ddr_rx_pkg.sv
package ddr_rx_pkg;
  localparam int unsigned LANES = 2;  // lane 0 in-phase, lane 1 quadrature
  typedef enum logic {ST_IDLE, ST_RUN} seq_st_e;
endpackage

// File: rtl/rdd_capture.sv
module rdd_capture
  import ddr_rx_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_i,
  input  logic [LANES-1:0]          lane_i,
  output logic [LANES-1:0][1:0]     pair_o,
  output logic                      start_o
);
  logic [LANES-1:0] pos_q;
  logic [LANES-1:0] neg_q;
  logic             fr_q, fr_qq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      fr_q  <= 1'b0;
      fr_qq <= 1'b0;
    end else begin
      pos_q <= lane_i;
      fr_q  <= frame_i;
      fr_qq <= fr_q;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= '0;
    else         neg_q <= lane_i;
  end

  // earlier (rising-edge) bit is the more significant of the pair
  for (genvar l = 0; l < LANES; l++) begin : g_pair
    assign pair_o[l] = {pos_q[l], neg_q[l]};
  end

  assign start_o = fr_q & ~fr_qq;
endmodule

// File: rtl/rdd_word_asm.sv
module rdd_word_asm #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        pair_i,
  input  logic              shift_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-3:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[WORD_W-5:0], pair_i};
  end

  assign word_o = {sh_q, pair_i};
endmodule

// File: rtl/rdd_frame_seq.sv
module rdd_frame_seq
  import ddr_rx_pkg::*;
#(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned N_CHAN   = 4,
  parameter int unsigned N_SAMPLE = 128,
  parameter int unsigned N_CHIRP  = 64,
  parameter int unsigned CH_W     = 2,
  parameter int unsigned SMP_W    = 7,
  parameter int unsigned CHP_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] i_word_i,
  input  logic [WORD_W-1:0] q_word_i,
  output logic              shift_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] i_o,
  output logic [WORD_W-1:0] q_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [SMP_W-1:0]  sample_o,
  output logic [CHP_W-1:0]  chirp_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              err_o
);
  localparam int unsigned PAIRS = WORD_W / 2;
  localparam int unsigned PC_W  = $clog2(PAIRS);

  seq_st_e           st_q;
  logic [PC_W-1:0]   pc_q;
  logic [CH_W-1:0]   ch_q;
  logic [SMP_W-1:0]  sm_q;
  logic [CHP_W-1:0]  cp_q;
  logic              running, word_done;
  logic              ch_last, sm_last, cp_last, first_word, last_word;

  assign running    = (st_q == ST_RUN);
  assign shift_o    = start_i | running;
  assign word_done  = running & ~start_i & (pc_q == PC_W'(PAIRS - 1));
  assign ch_last    = (ch_q == CH_W'(N_CHAN - 1));
  assign sm_last    = (sm_q == SMP_W'(N_SAMPLE - 1));
  assign cp_last    = (cp_q == CHP_W'(N_CHIRP - 1));
  assign last_word  = ch_last & sm_last & cp_last;
  assign first_word = (ch_q == '0) & (sm_q == '0) & (cp_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      i_o           <= '0;
      q_o           <= '0;
      chan_o        <= '0;
      sample_o      <= '0;
      chirp_o       <= '0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
    end else begin
      valid_o       <= word_done;
      frame_start_o <= word_done & first_word;
      frame_end_o   <= word_done & last_word;
      if (word_done) begin
        i_o      <= i_word_i;
        q_o      <= q_word_i;
        chan_o   <= ch_q;
        sample_o <= sm_q;
        chirp_o  <= cp_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      pc_q  <= '0;
      ch_q  <= '0;
      sm_q  <= '0;
      cp_q  <= '0;
      err_o <= 1'b0;
    end else if (start_i) begin
      // new frame edge: restart everything, flag a cut-short frame
      st_q <= ST_RUN;
      pc_q <= PC_W'(1);
      ch_q <= '0;
      sm_q <= '0;
      cp_q <= '0;
      if (running) err_o <= 1'b1;
    end else if (running) begin
      pc_q <= (pc_q == PC_W'(PAIRS - 1)) ? '0 : pc_q + 1'b1;
      if (word_done) begin
        ch_q <= ch_last ? '0 : ch_q + 1'b1;
        if (ch_last) begin
          sm_q <= sm_last ? '0 : sm_q + 1'b1;
          if (sm_last) cp_q <= cp_last ? '0 : cp_q + 1'b1;
        end
        if (last_word) st_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/radar_ddr_deser.sv
module radar_ddr_deser
  import ddr_rx_pkg::*;
#(
  parameter  int unsigned WORD_W   = 16,
  parameter  int unsigned N_CHAN   = 4,
  parameter  int unsigned N_SAMPLE = 128,
  parameter  int unsigned N_CHIRP  = 64,
  localparam int unsigned CH_W     = (N_CHAN   > 1) ? $clog2(N_CHAN)   : 1,
  localparam int unsigned SMP_W    = (N_SAMPLE > 1) ? $clog2(N_SAMPLE) : 1,
  localparam int unsigned CHP_W    = (N_CHIRP  > 1) ? $clog2(N_CHIRP)  : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [1:0]        lane_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] i_o,
  output logic [WORD_W-1:0] q_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [SMP_W-1:0]  sample_o,
  output logic [CHP_W-1:0]  chirp_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              err_o
);
  logic [LANES-1:0][1:0]        pair;
  logic [LANES-1:0][WORD_W-1:0] word;
  logic                         start, shift;

  rdd_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .lane_i  (lane_i),
    .pair_o  (pair),
    .start_o (start)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rdd_word_asm #(.WORD_W(WORD_W)) u_asm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pair_i  (pair[l]),
      .shift_i (shift),
      .word_o  (word[l])
    );
  end

  rdd_frame_seq #(
    .WORD_W(WORD_W), .N_CHAN(N_CHAN), .N_SAMPLE(N_SAMPLE), .N_CHIRP(N_CHIRP),
    .CH_W(CH_W), .SMP_W(SMP_W), .CHP_W(CHP_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .i_word_i      (word[0]),
    .q_word_i      (word[1]),
    .shift_o       (shift),
    .valid_o       (valid_o),
    .i_o           (i_o),
    .q_o           (q_o),
    .chan_o        (chan_o),
    .sample_o      (sample_o),
    .chirp_o       (chirp_o),
    .frame_start_o (frame_start_o),
    .frame_end_o   (frame_end_o),
    .err_o         (err_o)
  );
endmodule

// File: rtl/radar_ddr_deser_chk.sv
module radar_ddr_deser_chk #(
  parameter int unsigned N_CHAN   = 4,
  parameter int unsigned N_SAMPLE = 128,
  parameter int unsigned N_CHIRP  = 64,
  parameter int unsigned CH_W     = 2,
  parameter int unsigned SMP_W    = 7,
  parameter int unsigned CHP_W    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_o,
  input logic [CH_W-1:0]  chan_o,
  input logic [SMP_W-1:0] sample_o,
  input logic [CHP_W-1:0] chirp_o,
  input logic             frame_start_o,
  input logic             frame_end_o,
  input logic             err_o
);
  logic [CH_W-1:0] last_ch_q;
  logic            seen_q;
  logic [CH_W-1:0] next_ch;

  assign next_ch = (last_ch_q == CH_W'(N_CHAN - 1)) ? '0 : last_ch_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_ch_q <= '0;
      seen_q    <= 1'b0;
    end else if (valid_o) begin
      last_ch_q <= chan_o;
      seen_q    <= 1'b1;
    end
  end

  // R6
  first_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> valid_o && chan_o == '0 && sample_o == '0 && chirp_o == '0);

  // R7
  last_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> valid_o && chan_o == CH_W'(N_CHAN - 1)
                 && sample_o == SMP_W'(N_SAMPLE - 1) && chirp_o == CHP_W'(N_CHIRP - 1));

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R4
  chan_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q && !frame_start_o) |-> chan_o == next_ch);
endmodule

bind radar_ddr_deser radar_ddr_deser_chk #(
  .N_CHAN(N_CHAN), .N_SAMPLE(N_SAMPLE), .N_CHIRP(N_CHIRP),
  .CH_W(CH_W), .SMP_W(SMP_W), .CHP_W(CHP_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_o       (valid_o),
  .chan_o        (chan_o),
  .sample_o      (sample_o),
  .chirp_o       (chirp_o),
  .frame_start_o (frame_start_o),
  .frame_end_o   (frame_end_o),
  .err_o         (err_o)
);

// File: tb/radar_ddr_deser_tb_top.sv
module radar_ddr_deser_tb_top;
  localparam int W   = 16;
  localparam int NC  = 4;
  localparam int NS  = 2;
  localparam int NCH = 2;
  localparam int FW  = NC * NS * NCH;
  localparam int PPW = W / 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_i = 1'b0;
  logic [1:0]  lane_i = 2'b00;
  logic        valid_o, frame_start_o, frame_end_o, err_o;
  logic [W-1:0] i_o, q_o;
  logic [1:0]  chan_o;
  logic [0:0]  sample_o, chirp_o;

  radar_ddr_deser #(.WORD_W(W), .N_CHAN(NC), .N_SAMPLE(NS), .N_CHIRP(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i), .lane_i(lane_i),
    .valid_o(valid_o), .i_o(i_o), .q_o(q_o), .chan_o(chan_o),
    .sample_o(sample_o), .chirp_o(chirp_o), .frame_start_o(frame_start_o),
    .frame_end_o(frame_end_o), .err_o(err_o)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic [W-1:0] iv, qv;
    int          ch, sm, cp;
    bit          fs, fe;
  } exp_t;

  exp_t  exq[$];
  int    n_chk = 0;
  int    n_err = 0;
  int    err_due = -1;
  string tag = "R1";

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  function automatic logic [W-1:0] word_i(input int f, input int w);
    return W'((f * 16'h9e37) ^ (w * 16'h2c1b) ^ 16'ha5c3);
  endfunction

  function automatic logic [W-1:0] word_q(input int f, input int w);
    logic [W-1:0] x;
    x = word_i(f + 7, w + 3);
    return {x[7:0], x[15:8]} ^ 16'h0ff0;
  endfunction

  // per-clock comparison against the reference queue
  always @(negedge clk) begin
    exp_t e;
    bit   eerr;
    if (rst_ni) begin
      if (exq.size() > 0 && exq[0].due == cyc) begin
        e = exq.pop_front();
        chk(valid_o == 1'b1, "R5", "valid due", valid_o, 1);
        chk(i_o == e.iv, "R3", "i word", i_o, e.iv);
        chk(q_o == e.qv, "R3", "q word", q_o, e.qv);
        chk(int'(chan_o) == e.ch, "R4", "chan", chan_o, e.ch);
        chk(int'(sample_o) == e.sm, "R4", "sample", sample_o, e.sm);
        chk(int'(chirp_o) == e.cp, "R4", "chirp", chirp_o, e.cp);
        chk(frame_start_o == e.fs, "R6", "frame_start", frame_start_o, e.fs);
        chk(frame_end_o == e.fe, "R7", "frame_end", frame_end_o, e.fe);
      end else begin
        chk(valid_o == 1'b0, tag, "no word due", valid_o, 0);
      end
      eerr = (err_due >= 0) && (cyc >= err_due);
      chk(err_o == eerr, (err_due >= 0) ? "R8" : "R9", "err", err_o, eerr);
    end
  end

  task automatic drive_pair(input logic [1:0] ib, input logic [1:0] qb,
                            input logic fr, output int n);
    @(negedge clk); #1;
    lane_i  = {qb[1], ib[1]};
    frame_i = fr;
    n = cyc + 1;
    @(posedge clk); #1;
    lane_i = {qb[0], ib[0]};
  endtask

  task automatic idle(input int npairs, input string t);
    int n;
    tag = t;
    for (int p = 0; p < npairs; p++)
      drive_pair(2'(p * 3), 2'(p * 5 + 1), 1'b0, n);
  endtask

  // R2: frame line held high for four pairs; alignment must follow the edge
  task automatic send_frame(input int f, input int npairs, input bit early);
    int total, n, w, k;
    logic [W-1:0] iv, qv;
    exp_t e;
    tag = "R5";
    total = (npairs < 0) ? FW * PPW : npairs;
    for (int p = 0; p < total; p++) begin
      w  = p / PPW;
      k  = p % PPW;
      iv = word_i(f, w);
      qv = word_q(f, w);
      drive_pair(iv[W-1-2*k -: 2], qv[W-1-2*k -: 2], p < 4, n);
      if (p == 0 && early && err_due < 0) err_due = n + 1;  // R8
      if (k == PPW - 1) begin
        e.due = n + 1; e.iv = iv; e.qv = qv;
        e.ch = w % NC; e.sm = (w / NC) % NS; e.cp = w / (NC * NS);
        e.fs = (w == 0); e.fe = (w == FW - 1);
        exq.push_back(e);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1", "reset valid", valid_o, 0);
    chk(err_o == 1'b0, "R1", "reset err", err_o, 0);
    #1 rst_ni = 1'b1;
    idle(20, "R1");               // R1: junk before first edge
    send_frame(0, -1, 1'b0);      // R2 R3 R4
    send_frame(1, -1, 1'b0);      // R9: back-to-back frames
    idle(30, "R7");               // R7: junk after frame end
    send_frame(2, 43, 1'b0);      // R8: cut short after 5 words + 3 pairs
    send_frame(3, -1, 1'b1);      // R8: new frame recaptured
    idle(12, "R5");
    chk(exq.size() == 0, "R5", "words outstanding", exq.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R5 watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule